// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the address of the microinstruction that a microprogrammed control unit runs next. It holds the control address register, whose value goes out as the read address of control memory, and a one-entry return-address register for microcode subroutines. The microinstruction word that control memory returns for the current address is applied combinationally. The block splits that word into its fields. From the branch-type and condition fields, the opcode of the current machine instruction and three status flags, it computes the next control address, which is loaded on the next rising clock edge.

The three microoperation fields are passed straight through to the outputs, so that decoders outside the block can turn them into datapath controls. Four branch types are supported:

- a plain or conditional jump;
- a jump that also records a return point;
- a return to that point;
- a dispatch that converts the instruction opcode into the first address of its microcode routine, with four words reserved per routine.

When a jump or call is not taken, the address simply steps on by one, wrapping within the 128-word control memory.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous, active-high reset sets the control address to 64 and the return-address register to 0. A return issued as the first instruction after reset therefore goes to address 0.
- R2: The 20-bit word is split into fields as follows, and the three microoperation fields appear on their outputs in the same cycle:
  - bits [19:17] drive `uop_f1`;
  - bits [16:14] drive `uop_f2`;
  - bits [13:11] drive `uop_f3`;
  - bits [10:9] are the condition select;
  - bits [8:7] are the branch type;
  - bits [6:0] are the branch target.
- R3: The condition select encodes 00 = always true, 01 = indirect flag `ind_bit`, 10 = accumulator sign `ac_sign`, and 11 = accumulator-zero `ac_zero`.
- R4: For branch type 00 (jump), when the selected condition is true, the next address is the branch target.
- R5: For a jump or a call whose condition is false, the next address is the current address plus one, modulo 128 (127 is followed by 0).
- R6: For branch type 01 (call), when the condition is true, the next address is the branch target and the return-address register takes the current address plus one, modulo 128.
- R7: The return-address register changes only on a taken call. An untaken call, a jump, a return and a dispatch all leave it unchanged.
- R8: For branch type 10 (return), the next address is the return-address register. The condition and target fields have no effect.
- R9: For branch type 11 (dispatch), the next address is {0, opcode[3:0], 00}, so routines start at addresses 0, 4, …, 60. The condition and target fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| uword | input | 20 | Microinstruction read from control memory at `car` |
| opcode | input | 4 | Opcode of the current machine instruction |
| ind_bit | input | 1 | Indirect-addressing bit of the instruction |
| ac_sign | input | 1 | Accumulator sign flag |
| ac_zero | input | 1 | Accumulator-is-zero flag |
| car | output | 7 | Current control address (control memory read address) |
| uop_f1 | output | 3 | First microoperation field |
| uop_f2 | output | 3 | Second microoperation field |
| uop_f3 | output | 3 | Third microoperation field |

## Verification
The assertions check four rules on every cycle:

- the address loaded for each branch type, whether a jump or call is taken or falls through;
- the value saved on a taken call;
- that the return register holds still otherwise;
- that the fetch address follows release of reset.

Only the bench's scenarios can show two further properties: that a return lands on a value saved several instructions earlier, across untaken calls and dispatches, and that a complete fetch, dispatch and indirect-subroutine microprogram walks through the expected address trace.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int CD_W = 2;
  localparam int BR_W = 2;

  typedef enum logic [CD_W-1:0] {
    CD_ALWAYS = 2'b00,
    CD_IND    = 2'b01,
    CD_SIGN   = 2'b10,
    CD_ZERO   = 2'b11
  } cond_sel_e;

  typedef enum logic [BR_W-1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_kind_e;
endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
  import useq_pkg::*;
(
  input  cond_sel_e sel,
  input  logic      ind_bit,
  input  logic      ac_sign,
  input  logic      ac_zero,
  output logic      cond_true
);
  always_comb begin
    unique case (sel)
      CD_ALWAYS: cond_true = 1'b1;
      CD_IND:    cond_true = ind_bit;
      CD_SIGN:   cond_true = ac_sign;
      CD_ZERO:   cond_true = ac_zero;
    endcase
  end
endmodule

// File: rtl/useq_fields.sv
module useq_fields #(
  parameter int FW     = 3,
  parameter int NUM_F  = 3,
  parameter int WORD_W = 20
) (
  input  logic [WORD_W-1:0]          word,
  output logic [NUM_F-1:0][FW-1:0]   fields
);
  for (genvar k = 0; k < NUM_F; k++) begin : g_field
    // Field 0 sits at the top of the word, later fields follow downward.
    assign fields[k] = word[WORD_W-1-k*FW -: FW];
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int OPC_W  = 4
) (
  input  logic [ADDR_W-1:0] car_cur,
  input  logic [ADDR_W-1:0] sbr_cur,
  input  br_kind_e          kind,
  input  logic [ADDR_W-1:0] target,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              cond_true,
  output logic [ADDR_W-1:0] car_nxt,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              save_ret
);
  // Step by one; the carry out of the top bit is dropped, so the address wraps.
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // Opcode placed above two zero bits; every upper bit is zero.
  function automatic logic [ADDR_W-1:0] dispatch_addr(input logic [OPC_W-1:0] op);
    return ADDR_W'(op) << 2;
  endfunction

  assign ret_addr = step_addr(car_cur);
  assign save_ret = (kind == BR_CALL) && cond_true;

  always_comb begin
    unique case (kind)
      BR_JUMP, BR_CALL: car_nxt = cond_true ? target : ret_addr;
      BR_RET:           car_nxt = sbr_cur;
      BR_MAP:           car_nxt = dispatch_addr(opcode);
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OPC_W      = 4,
  parameter int FW         = 3,
  parameter int START_ADDR = 64,
  localparam int NUM_F     = 3,
  localparam int WORD_W    = NUM_F*FW + CD_W + BR_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] uword,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              ind_bit,
  input  logic              ac_sign,
  input  logic              ac_zero,
  output logic [ADDR_W-1:0] car,
  output logic [FW-1:0]     uop_f1,
  output logic [FW-1:0]     uop_f2,
  output logic [FW-1:0]     uop_f3
);
  logic [ADDR_W-1:0]        car_q, sbr_q, car_nxt, ret_addr, target;
  logic                     cond_true, save_ret;
  cond_sel_e                cd;
  br_kind_e                 br;
  logic [NUM_F-1:0][FW-1:0] fields;

  assign cd     = cond_sel_e'(uword[ADDR_W+BR_W +: CD_W]);
  assign br     = br_kind_e'(uword[ADDR_W +: BR_W]);
  assign target = uword[ADDR_W-1:0];

  useq_fields #(.FW(FW), .NUM_F(NUM_F), .WORD_W(WORD_W)) u_fields (
    .word(uword), .fields(fields)
  );

  assign uop_f1 = fields[0];
  assign uop_f2 = fields[1];
  assign uop_f3 = fields[2];

  useq_cond_sel u_cond (
    .sel(cd), .ind_bit(ind_bit), .ac_sign(ac_sign), .ac_zero(ac_zero),
    .cond_true(cond_true)
  );

  useq_next_addr #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_next (
    .car_cur(car_q), .sbr_cur(sbr_q), .kind(br), .target(target),
    .opcode(opcode), .cond_true(cond_true),
    .car_nxt(car_nxt), .ret_addr(ret_addr), .save_ret(save_ret)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q <= ADDR_W'(START_ADDR);
      sbr_q <= '0;
    end else begin
      car_q <= car_nxt;
      if (save_ret) sbr_q <= ret_addr;
    end
  end

  assign car = car_q;

  AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (car_q == ADDR_W'(START_ADDR) && sbr_q == '0)); // R1

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
    ((br == BR_JUMP || br == BR_CALL) && cond_true) |=> car_q == $past(target)); // R4

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    ((br == BR_JUMP || br == BR_CALL) && !cond_true)
      |=> car_q == ADDR_W'($past(car_q) + ADDR_W'(1))); // R5

  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (rst)
    (br == BR_CALL && cond_true) |=> sbr_q == ADDR_W'($past(car_q) + ADDR_W'(1))); // R6

  AST_SBR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(br == BR_CALL && cond_true) |=> $stable(sbr_q)); // R7

  AST_RET_LOAD: assert property (@(posedge clk) disable iff (rst)
    (br == BR_RET) |=> car_q == $past(sbr_q)); // R8

  AST_MAP_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (br == BR_MAP) |=> (car_q[1:0] == 2'b00 && car_q[ADDR_W-1] == 1'b0)); // R9
endmodule

// File: tb/tb_useq_sequencer.sv
module tb_useq_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] uword = '0;
  logic [3:0]  opcode = '0;
  logic        ind_bit = 1'b0, ac_sign = 1'b0, ac_zero = 1'b0;
  logic [6:0]  car;
  logic [2:0]  uop_f1, uop_f2, uop_f3;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [6:0] m_car, m_sbr;

  always #4 clk = ~clk;

  useq_sequencer dut (
    .clk(clk), .rst(rst), .uword(uword), .opcode(opcode),
    .ind_bit(ind_bit), .ac_sign(ac_sign), .ac_zero(ac_zero),
    .car(car), .uop_f1(uop_f1), .uop_f2(uop_f2), .uop_f3(uop_f3)
  );

  function automatic logic [19:0] mk(input logic [2:0] f1, f2, f3,
                                     input logic [1:0] cd, br,
                                     input logic [6:0] ad);
    return {f1, f2, f3, cd, br, ad};
  endfunction

  // R3: condition bits 00 always, 01 indirect, 10 sign, 11 zero.
  function automatic bit pick_cond(input logic [1:0] cd, input bit i, s, z);
    if (cd == 2'd0) return 1'b1;
    if (cd == 2'd1) return i;
    if (cd == 2'd2) return s;
    return z;
  endfunction

  // Small microprogram: fetch at 64..66, indirect subroutine at 67..68.
  function automatic logic [19:0] cmem(input logic [6:0] a);
    case (a)
      7'd64: return mk(3'd6, 3'd0, 3'd0, 2'd0, 2'd0, 7'd65);
      7'd65: return mk(3'd0, 3'd4, 3'd5, 2'd0, 2'd0, 7'd66);
      7'd66: return mk(3'd0, 3'd0, 3'd0, 2'd0, 2'd3, 7'd0);
      7'd67: return mk(3'd0, 3'd4, 3'd0, 2'd0, 2'd0, 7'd68);
      7'd68: return mk(3'd5, 3'd0, 3'd0, 2'd0, 2'd2, 7'd0);
      7'd0:  return mk(3'd0, 3'd0, 3'd0, 2'd1, 2'd1, 7'd67);
      7'd1:  return mk(3'd0, 3'd4, 3'd0, 2'd0, 2'd0, 7'd2);
      7'd2:  return mk(3'd1, 3'd0, 3'd0, 2'd0, 2'd0, 7'd64);
      default:
        if (a < 7'd64 && a[1:0] == 2'b00)
          return mk(3'd2, 3'd0, 3'd0, 2'd3, 2'd1, 7'd67);
        else
          return mk(3'd0, 3'd0, 3'd7, 2'd2, 2'd0, 7'd64);
    endcase
  endfunction

  task automatic check7(input string tag, input logic [6:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [19:0] w, input logic [3:0] opc,
                      input bit i, s, z, input string tag_in);
    logic [1:0] cd, br;
    bit         c;
    logic [6:0] exp_car, exp_sbr;
    string      tag;
    @(negedge clk);
    uword = w; opcode = opc; ind_bit = i; ac_sign = s; ac_zero = z;
    #1;
    check7("R2 f1", {4'd0, uop_f1}, {4'd0, w[19:17]});
    check7("R2 f2", {4'd0, uop_f2}, {4'd0, w[16:14]});
    check7("R2 f3", {4'd0, uop_f3}, {4'd0, w[13:11]});
    cd = w[10:9];
    br = w[8:7];
    c  = pick_cond(cd, i, s, z);
    exp_sbr = m_sbr;
    if (br == 2'd2) begin
      exp_car = m_sbr; tag = "R8";
    end else if (br == 2'd3) begin
      exp_car = {1'b0, opc, 2'b00}; tag = "R9";
    end else if (c) begin
      exp_car = w[6:0];
      if (br == 2'd1) begin
        exp_sbr = m_car + 7'd1; tag = "R6 R3";
      end else tag = "R4 R3";
    end else begin
      exp_car = m_car + 7'd1;
      tag = (br == 2'd1) ? "R7 R5 R3" : "R5 R3";
    end
    if (tag_in != "") tag = tag_in;
    @(posedge clk);
    #2;
    check7(tag, car, exp_car);
    m_car = exp_car;
    m_sbr = exp_sbr;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check7("R1 reset car", car, 7'd64);
    rst = 1'b0;
    m_car = 7'd64;
    m_sbr = 7'd0;

    // R1: return right after reset goes to 0 (return register cleared).
    step(mk(3'd0, 3'd0, 3'd0, 2'd3, 2'd2, 7'd99), 4'd0, 1, 1, 1, "R1 R8");

    // R5 wrap: jump to 127, then an untaken conditional jump.
    step(mk(3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 7'd127), 4'd0, 0, 0, 0, "R4");
    step(mk(3'd0, 3'd0, 3'd0, 2'd1, 2'd0, 7'd50), 4'd0, 0, 1, 1, "R5 wrap");

    // R6 wrap: taken call at 127 saves 0.
    step(mk(3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 7'd127), 4'd0, 0, 0, 0, "R4");
    step(mk(3'd0, 3'd0, 3'd0, 2'd2, 2'd1, 7'd10), 4'd0, 0, 1, 0, "R6 wrap");
    step(mk(3'd0, 3'd0, 3'd0, 2'd1, 2'd2, 7'd33), 4'd0, 1, 0, 0, "R8 after wrap");

    // R7: the saved value survives an untaken call, a dispatch and a jump.
    step(mk(3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 7'd20), 4'd0, 0, 0, 0, "R4");
    step(mk(3'd0, 3'd0, 3'd0, 2'd3, 2'd1, 7'd40), 4'd0, 0, 0, 1, "R6");
    step(mk(3'd0, 3'd0, 3'd0, 2'd1, 2'd1, 7'd90), 4'd0, 0, 1, 1, "R7 untaken call");
    step(mk(3'd0, 3'd0, 3'd0, 2'd2, 2'd3, 7'd77), 4'd5, 0, 1, 0, "R9");
    step(mk(3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 7'd100), 4'd0, 0, 0, 0, "R4");
    step(mk(3'd0, 3'd0, 3'd0, 2'd0, 2'd2, 7'd5), 4'd0, 0, 0, 0, "R7 ret 21");

    // R9 extremes with junk in condition and target.
    step(mk(3'd7, 3'd7, 3'd7, 2'd3, 2'd3, 7'd127), 4'd15, 1, 1, 1, "R9 op15");
    step(mk(3'd0, 3'd0, 3'd0, 2'd1, 2'd3, 7'd127), 4'd0, 1, 1, 1, "R9 op0");

    // R3: each condition, true then false.
    for (int k = 0; k < 4; k++) begin
      step(mk(3'd0, 3'd0, 3'd0, 2'(k), 2'd0, 7'd30), 4'd0,
           k == 1, k == 2, k == 3, "");
      step(mk(3'd0, 3'd0, 3'd0, 2'(k), 2'd0, 7'd30), 4'd0,
           k != 1, k != 2, k != 3, "");
    end

    // Microprogram run: fetch, dispatch, conditional indirect call.
    step(mk(3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 7'd64), 4'd0, 0, 0, 0, "R4");
    for (int n = 0; n < 600; n++) begin
      step(cmem(m_car), 4'($urandom_range(0, 15)), 1'($urandom),
           1'($urandom), 1'($urandom), "");
    end

    // Random words.
    for (int n = 0; n < 3000; n++) begin
      step(20'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), "");
    end

    // R1: reset mid-run returns to fetch.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check7("R1 re-reset", car, 7'd64);
    rst = 1'b0;
    m_car = 7'd64;
    m_sbr = 7'd0;
    step(mk(3'd0, 3'd0, 3'd0, 2'd0, 2'd2, 7'd9), 4'd3, 0, 0, 0, "R1 sbr cleared");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule